// File: doc/BRIEF.md
# Synchronous Burst Word Memory with Byte Lanes

This block is a clocked single-port word memory with a burst address counter. An access begins on a rising clock edge when three chip enables are in their active state and one of two address strobes is low. The strobe from the processor side wins over the strobe from the controller side. The presented address goes into an address register. Its two low bits seed a 2-bit wrapping counter. A separate active-low advance input then walks the counter through four words. The order is either linear (seed plus step, modulo 4) or interleaved (seed XOR step), and a mode pin selects it.

Writes are started by the controller strobe, or they continue inside an active burst. Each write enables 8-bit lanes through a global write input, or through a byte-write enable together with per-lane selects. The read path is flow-through: the word at the current burst address appears on the output in the cycle after the access starts. The shared data bus is modelled as split ports, `dqIn`, `dqOut` and a drive enable `dqOutEn`, and the pad tristate sits outside the block. The drive enable drops whenever the write inputs signal a write, whatever the output-enable pin says.

Top module: `burst_sram`

## Requirements
- R1: After reset no access is active and `dqOutEn` is 0 until an access starts.
- R2: With `csAN`=0, `csB`=1, `csCN`=0, `ctlStrobeN`=0, `cpuStrobeN`=1 and `globalWrN`=0 at a clock edge, the full `dqIn` word is written at `addr`.
- R3: A strobe edge with any chip enable inactive starts nothing, writes nothing and ends an active burst, so `dqOutEn` stays 0 afterwards.
- R4: When `cpuStrobeN`=0 at a selected edge, a read access starts at `addr`; `ctlStrobeN` and all write inputs on that edge are ignored, and memory is unchanged.
- R5: With `globalWrN`=1 and `byteWrEnN`=0, lane k (bits 8k+7:8k) is written only when `laneWrN[k]`=0; with `globalWrN`=0 all four lanes are written.
- R6: `dqOutEn` is 0 in any cycle where `globalWrN`=0, or where `byteWrEnN`=0 with at least one `laneWrN` bit 0, regardless of `outEnN`.
- R7: `dqOutEn` is 1 exactly when a burst is active, `outEnN`=0 and no write is signalled; `dqOut` then shows the word at the current burst address, starting in the cycle after the access edge.
- R8: With `burstInterleave`=0, each edge inside a burst with both strobes high and `advanceN`=0 moves the low two address bits to seed+k mod 4 (seed 01 gives 01,10,11,00), and the upper bits stay fixed.
- R9: With `burstInterleave`=1, the k-th word of a burst has low bits seed XOR k (seed 10 gives 10,11,00,01).
- R10: With `advanceN`=1 and both strobes high, the burst address holds.
- R11: A write signalled in a burst cycle with both strobes high goes to the address reached on that edge, after any advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of control state |
| csAN | input | 1 | Chip enable, active low |
| csB | input | 1 | Chip enable, active high |
| csCN | input | 1 | Chip enable, active low |
| cpuStrobeN | input | 1 | Processor-side address strobe, active low, higher priority |
| ctlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Enables per-lane writes, active low |
| laneWrN | input | 4 | Per-lane write selects, active low, bit k is lane k |
| outEnN | input | 1 | Output enable, active low |
| burstInterleave | input | 1 | 1 selects interleaved order, 0 selects linear |
| addr | input | ADDR_W | Word address |
| dqIn | input | 32 | Write data from the bus |
| dqOut | output | 32 | Read data toward the bus |
| dqOutEn | output | 1 | Bus drive enable |

## Verification
The bench builds the block with `ADDR_W`=6, so there are 64 words. It preloads every word with a value that encodes its own address, so any data read back shows which address was hit. With this small depth, random starts revisit the same words often. They also land on all four seed values, so merged byte writes, overwrites and both burst orders meet at every wrap point within a few hundred cycles.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned DATA_W    = LANE_W * NUM_LANES;
  localparam int unsigned CNT_W     = 2;

  typedef struct packed {
    logic                 loadAddr;
    logic                 stepCnt;
    logic                 writeEn;
    logic [NUM_LANES-1:0] laneMask;
  } ctrlStrobes_t;

  function automatic logic [CNT_W-1:0] burstOffset(
    input logic [CNT_W-1:0] seed,
    input logic [CNT_W-1:0] step,
    input logic             interleave
  );
    return interleave ? (seed ^ step) : (seed + step);
  endfunction
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csAN,
  input  logic                 csB,
  input  logic                 csCN,
  input  logic                 cpuStrobeN,
  input  logic                 ctlStrobeN,
  input  logic                 advanceN,
  input  logic                 globalWrN,
  input  logic                 byteWrEnN,
  input  logic [NUM_LANES-1:0] laneWrN,
  input  logic                 outEnN,
  output ctrlStrobes_t         strobes,
  output logic                 burstActive,
  output logic                 dqOutEn
);
  logic selected, cpuGo, ctlGo, anyStrobe, writeSeen, inBurst;
  logic [NUM_LANES-1:0] laneReq;

  always_comb begin
    selected  = !csAN && csB && !csCN;
    anyStrobe = !cpuStrobeN || !ctlStrobeN;
    cpuGo     = selected && !cpuStrobeN;
    ctlGo     = selected && cpuStrobeN && !ctlStrobeN;
    if (!globalWrN)      laneReq = '1;
    else if (!byteWrEnN) laneReq = ~laneWrN;
    else                 laneReq = '0;
    writeSeen = |laneReq;
    inBurst   = burstActive && !anyStrobe;

    strobes.loadAddr = cpuGo || ctlGo;
    strobes.stepCnt  = inBurst && !advanceN;
    strobes.writeEn  = (ctlGo || inBurst) && writeSeen;
    strobes.laneMask = laneReq;

    dqOutEn = burstActive && !outEnN && !writeSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          burstActive <= 1'b0;
    else if (anyStrobe) burstActive <= selected;
  end
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              burstInterleave,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic [ADDR_W-1:0] wordAddr
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned BASE_W = ADDR_W - CNT_W;

  logic [BASE_W-1:0] baseQ;
  logic [CNT_W-1:0]  seedQ, cntQ, cntNext;
  logic [ADDR_W-1:0] wrAddr;

  always_comb begin
    cntNext  = strobes.stepCnt ? cntQ + 1'b1 : cntQ;
    wordAddr = {baseQ, burstOffset(seedQ, cntQ, burstInterleave)};
    wrAddr   = strobes.loadAddr ? addr
                                : {baseQ, burstOffset(seedQ, cntNext, burstInterleave)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      seedQ <= '0;
      cntQ  <= '0;
    end else if (strobes.loadAddr) begin
      baseQ <= addr[ADDR_W-1:CNT_W];
      seedQ <= addr[CNT_W-1:0];
      cntQ  <= '0;
    end else begin
      cntQ  <= cntNext;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strobes.writeEn && strobes.laneMask[g])
        laneMem[wrAddr] <= dqIn[g*LANE_W +: LANE_W];
    end
    assign dqOut[g*LANE_W +: LANE_W] = laneMem[wordAddr];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csAN,
  input  logic              csB,
  input  logic              csCN,
  input  logic              cpuStrobeN,
  input  logic              ctlStrobeN,
  input  logic              advanceN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [3:0]        laneWrN,
  input  logic              outEnN,
  input  logic              burstInterleave,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       dqIn,
  output logic [31:0]       dqOut,
  output logic              dqOutEn
);
  ctrlStrobes_t      strobes;
  logic              burstActive;
  logic [ADDR_W-1:0] wordAddr;

  burst_sram_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .csAN(csAN), .csB(csB), .csCN(csCN),
    .cpuStrobeN(cpuStrobeN), .ctlStrobeN(ctlStrobeN), .advanceN(advanceN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .outEnN(outEnN), .strobes(strobes), .burstActive(burstActive),
    .dqOutEn(dqOutEn)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .burstInterleave(burstInterleave), .addr(addr), .dqIn(dqIn),
    .dqOut(dqOut), .wordAddr(wordAddr)
  );
endmodule

// File: rtl/burst_sram_checker.sv
module burst_sram_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csAN,
  input logic              csB,
  input logic              csCN,
  input logic              cpuStrobeN,
  input logic              ctlStrobeN,
  input logic              advanceN,
  input logic              globalWrN,
  input logic              byteWrEnN,
  input logic [3:0]        laneWrN,
  input logic              outEnN,
  input logic              burstInterleave,
  input logic              dqOutEn,
  input logic              burstActive,
  input logic [ADDR_W-1:0] wordAddr
);
  logic sel, anyStb;
  assign sel    = !csAN && csB && !csCN;
  assign anyStb = !cpuStrobeN || !ctlStrobeN;

  a_r6_release_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (!globalWrN || (!byteWrEnN && laneWrN != 4'hF)) |-> !dqOutEn);

  a_r7_oe_gate: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dqOutEn);

  a_r3_deselect_ends: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && !sel) |=> (!burstActive && !dqOutEn));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && !anyStb && advanceN) |=>
      ($past(burstInterleave) != burstInterleave || $stable(wordAddr)));

  a_r8_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && !anyStb && !advanceN && !burstInterleave) |=>
      (burstInterleave || wordAddr[1:0] == $past(wordAddr[1:0]) + 2'd1));

  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && !anyStb) |=> $stable(wordAddr[ADDR_W-1:2]));
endmodule

bind burst_sram burst_sram_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .csAN(csAN), .csB(csB), .csCN(csCN),
  .cpuStrobeN(cpuStrobeN), .ctlStrobeN(ctlStrobeN), .advanceN(advanceN),
  .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
  .outEnN(outEnN), .burstInterleave(burstInterleave), .dqOutEn(dqOutEn),
  .burstActive(burstActive), .wordAddr(wordAddr)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int unsigned AW = 6;
  localparam int unsigned WORDS = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0;
  logic csAN, csB, csCN, cpuStrobeN, ctlStrobeN, advanceN;
  logic globalWrN, byteWrEnN, outEnN, burstInterleave;
  logic [3:0] laneWrN;
  logic [AW-1:0] addr;
  logic [31:0] dqIn, dqOut;
  logic dqOutEn;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] refMem [WORDS];
  bit refActive = 0;
  logic [1:0] refSeed = 0, refCnt = 0;
  logic [AW-3:0] refBase = 0;

  always #10 clk = ~clk;

  burst_sram #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .csAN(csAN), .csB(csB), .csCN(csCN),
    .cpuStrobeN(cpuStrobeN), .ctlStrobeN(ctlStrobeN), .advanceN(advanceN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .outEnN(outEnN), .burstInterleave(burstInterleave), .addr(addr),
    .dqIn(dqIn), .dqOut(dqOut), .dqOutEn(dqOutEn)
  );

  function automatic logic [31:0] pat(input int a);
    return {8'hC3, 8'(a), 8'h5A, ~8'(a)};
  endfunction

  function automatic logic [3:0] lanesReq();
    if (!globalWrN) return 4'hF;
    if (!byteWrEnN) return ~laneWrN;
    return 4'h0;
  endfunction

  function automatic logic [AW-1:0] refAddrOf(input logic [1:0] c);
    logic [1:0] lo;
    lo = burstInterleave ? (refSeed ^ c) : (refSeed + c);
    return {refBase, lo};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                       input logic [3:0] m);
    logic [31:0] r;
    r = old;
    for (int k = 0; k < 4; k++) if (m[k]) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    csAN = 0; csB = 1; csCN = 0; cpuStrobeN = 1; ctlStrobeN = 1; advanceN = 1;
    globalWrN = 1; byteWrEnN = 1; laneWrN = 4'hF; outEnN = 0;
  endtask

  // One clock: check outputs late in the cycle, then step the reference model.
  task automatic tick(input string tag, input bit chkData = 0, input logic [31:0] expData = 0);
    bit expEn, sel, cpuGo, ctlGo, anyStb;
    logic [3:0] m;
    logic [1:0] nc;
    #17;
    m = lanesReq();
    expEn = refActive && !outEnN && (m == 0);
    check(dqOutEn == expEn, tag, {31'd0, dqOutEn}, {31'd0, expEn});
    if (expEn)
      check(dqOut == refMem[refAddrOf(refCnt)], tag, dqOut, refMem[refAddrOf(refCnt)]);
    if (chkData) check(dqOutEn && dqOut == expData, tag, dqOut, expData);
    @(posedge clk);
    sel = !csAN && csB && !csCN;
    anyStb = !cpuStrobeN || !ctlStrobeN;
    cpuGo = sel && !cpuStrobeN;
    ctlGo = sel && cpuStrobeN && !ctlStrobeN;
    nc = (refActive && !anyStb && !advanceN) ? refCnt + 2'd1 : refCnt;
    if (ctlGo && m != 0) refMem[addr] = merge(refMem[addr], dqIn, m);
    else if (refActive && !anyStb && m != 0)
      refMem[refAddrOf(nc)] = merge(refMem[refAddrOf(nc)], dqIn, m);
    if (cpuGo || ctlGo) begin
      refSeed = addr[1:0]; refBase = addr[AW-1:2]; refCnt = 0;
    end else refCnt = nc;
    if (anyStb) refActive = sel;
    #1;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    idle(); burstInterleave = 0; addr = 0; dqIn = 0;
    for (int i = 0; i < WORDS; i++) refMem[i] = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    check(dqOutEn == 1'b0, "R1 reset bus released", {31'd0, dqOutEn}, 32'd0);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    tick("R1 idle after reset");

    // R2: preload every word with full-word writes
    for (int i = 0; i < WORDS; i++) begin
      ctlStrobeN = 0; globalWrN = 0; addr = AW'(i); dqIn = pat(i);
      tick("R2 write");
    end
    idle();
    ctlStrobeN = 0; addr = 6'h2A; tick("R2 read start");
    idle(); tick("R2 readback", 1, pat(6'h2A));

    // R8 linear burst from 0x0D: 0D,0E,0F,0C
    ctlStrobeN = 0; addr = 6'h0D; tick("R8 start");
    idle(); advanceN = 0; tick("R8 word0", 1, pat(6'h0D));
    tick("R8 word1", 1, pat(6'h0E));
    tick("R8 word2", 1, pat(6'h0F));
    advanceN = 1; tick("R8 word3 wrap", 1, pat(6'h0C));
    tick("R10 hold", 1, pat(6'h0C));

    // R9 interleaved burst from 0x0E: 0E,0F,0C,0D
    burstInterleave = 1;
    cpuStrobeN = 0; addr = 6'h0E; tick("R9 start");
    idle(); advanceN = 0; tick("R9 word0", 1, pat(6'h0E));
    tick("R9 word1", 1, pat(6'h0F));
    tick("R9 word2", 1, pat(6'h0C));
    advanceN = 1; tick("R9 word3", 1, pat(6'h0D));
    burstInterleave = 0;

    // R5 byte lanes 0 and 2
    idle(); ctlStrobeN = 0; byteWrEnN = 0; laneWrN = 4'b1010; addr = 6'h11;
    dqIn = 32'h11223344; tick("R5 byte write");
    idle(); ctlStrobeN = 0; addr = 6'h11; tick("R5 read start");
    idle(); tick("R5 lanes merged", 1, {8'hC3, 8'h22, 8'h5A, 8'h44});

    // R4 processor strobe wins: write inputs ignored
    cpuStrobeN = 0; ctlStrobeN = 0; globalWrN = 0; addr = 6'h20; dqIn = 32'hDEADBEEF;
    tick("R6 release during cpu strobe");
    idle(); tick("R4 memory unchanged", 1, pat(6'h20));

    // R6 partial write inside burst with OE asserted
    byteWrEnN = 0; laneWrN = 4'b0111; dqIn = 32'hAB000000;
    tick("R6 partial write releases bus");
    idle(); tick("R11 hold-write landed", 1, {8'hAB, 8'h20, 8'h5A, 8'hDF});

    // R11 burst write at 0x31: 31,32,33,30
    ctlStrobeN = 0; globalWrN = 0; addr = 6'h31; dqIn = 32'hA0A0A0A0; tick("R11 first");
    idle(); advanceN = 0; globalWrN = 0;
    dqIn = 32'hA1A1A1A1; tick("R11 second");
    dqIn = 32'hA2A2A2A2; tick("R11 third");
    dqIn = 32'hA3A3A3A3; tick("R11 fourth");
    idle(); cpuStrobeN = 0; addr = 6'h30; tick("R11 read start");
    idle(); tick("R11 word 30", 1, 32'hA3A3A3A3);

    // R3 deselected write starts nothing and ends the burst
    csB = 0; ctlStrobeN = 0; globalWrN = 0; addr = 6'h05; dqIn = 32'h0;
    tick("R3 deselected strobe");
    idle(); tick("R3 burst ended");
    ctlStrobeN = 0; addr = 6'h05; tick("R3 read start");
    idle(); tick("R3 word unchanged", 1, pat(6'h05));
    outEnN = 1; tick("R7 oe high");

    // random phase
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      idle();
      csAN = (r[3:0] == 0); csB = (r[7:4] != 0); csCN = (r[11:8] == 0);
      cpuStrobeN = (r[14:12] != 0); ctlStrobeN = (r[17:15] != 0);
      advanceN = r[18]; outEnN = (r[21:19] == 0);
      globalWrN = (r[24:22] != 0); byteWrEnN = (r[26:25] != 0); laneWrN = r[30:27];
      if (n % 50 == 0) burstInterleave = r[31];
      addr = AW'($urandom); dqIn = $urandom;
      tick((lanesReq() != 0) ? "R6 random" : "R7 random");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule